// File: doc/BRIEF.md
# Block-Bit Exception Acceptance Controller

This controller sits at the instruction boundary of a processor core. At each boundary it decides whether a pending event is taken. The events are a reset request, a synchronous exception, a user-break trap, a non-maskable interrupt or a maskable interrupt. When none of these is taken, a return-from-exception request proceeds instead. The controller owns the status register (SR), the saved PC and saved SR, the vector base and the event-code register. It issues a registered jump request with the target address.

A single SR block bit drives all of the gating. While the bit is set, the controller holds off maskable interrupts and drops user-break conditions. It turns any other exception into a jump to the fixed reset address. That jump does not touch the status pins. Two conditions still let an interrupt through while the bit is set: a sleep/standby indication, and a mask-override control bit that applies to the non-maskable interrupt only. Taking a normal event saves PC and SR and sets the block bit in the same cycle. A return restores SR from the saved copy and jumps to the saved PC.

Top module: `bl_accept_ctrl`

## Requirements
- R1: With SR bit 28 (block bit) at 1 and the sleep input low, a maskable interrupt request is not taken: the jump output stays low.
- R2: If SR is written with the block bit cleared at the same boundary where an interrupt is pending, that boundary takes nothing. The interrupt is taken at the next boundary.
- R3: With the sleep input high, maskable and non-maskable interrupts are taken even when the block bit is 1.
- R4: A non-maskable interrupt is taken when the block bit is 0. With the block bit at 1 and sleep low, it is taken only when the override input is 1. Its event code is 0x1C0 and its target is vector base + 0x600.
- R5: With the block bit at 1, a user-break request is ignored: no jump, and SR is unchanged. With the block bit at 0, it jumps to vector base + 0x100 with event code 0x1E0.
- R6: An exception raised while the block bit is 1 jumps to 0xA0000000 with the status enable output low.
- R7: A reset request jumps to 0xA0000000 with status enable high and status value 2'b11. It loads SR with 0x700000F0 and clears the vector base.
- R8: A return request that is not pre-empted jumps to the saved PC and loads SR from the saved SR.
- R9: After the reset pin is released, the vector base is 0, SR is 0x700000F0, the event code is 0 and no jump is issued.
- R10: A taken exception, break, non-maskable or maskable interrupt has four effects. It stores the boundary PC as saved PC and the prior SR as saved SR. It sets the block bit and keeps the other SR bits. It loads the event code: the exception code input for an exception, the interrupt code input for a maskable interrupt. Exceptions jump to vector base + 0x100 and interrupts to vector base + 0x600.
- R11: At one boundary the priority order is: reset request, then exception (either the normal exception or the block-bit redirect), then user break, then non-maskable interrupt, then maskable interrupt, then return.
- R12: Software writes to SR and to the vector base are dropped at any boundary where an event or return is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| bnd_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 32 | PC to save when an event is taken |
| sleep_i | input | 1 | Core is in sleep or standby |
| nmi_ovr_i | input | 1 | Lets the non-maskable interrupt through while blocked |
| rst_req_i | input | 1 | Reset request |
| exc_req_i | input | 1 | Exception request |
| exc_code_i | input | 12 | Code of the exception |
| brk_req_i | input | 1 | User-break condition met |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| irq_req_i | input | 1 | Maskable interrupt request (already level-qualified) |
| irq_code_i | input | 12 | Code of the maskable interrupt |
| rte_i | input | 1 | Return-from-exception at this boundary |
| sr_we_i | input | 1 | Software SR write |
| sr_wdata_i | input | 32 | SR write value |
| vbr_we_i | input | 1 | Software vector base write |
| vbr_wdata_i | input | 32 | Vector base write value |
| jump_o | output | 1 | One-cycle jump request |
| jump_pc_o | output | 32 | Jump target |
| stat_en_o | output | 1 | Status pins driven |
| stat_o | output | 2 | Status pin value |
| sr_o | output | 32 | Status register |
| spc_o | output | 32 | Saved PC |
| ssr_o | output | 32 | Saved SR |
| vbr_o | output | 32 | Vector base |
| evt_o | output | 12 | Code of last taken event |

## Verification
The sharpest coincidence is a software SR write and event acceptance landing on the same boundary. The bench provokes it in both directions. In the first, a write that clears the block bit meets a pending interrupt, and the judgement is that the jump appears only one boundary later. In the second, an SR or vector base write arrives with an event that is taken anyway, and the judgement is that the taken event's SR value and the old vector base survive. A sweep over every combination of block bit, sleep, override and the six request lines also makes several events compete at one boundary. Each result is compared with a priority model computed in the bench.

// File: rtl/blx_pkg.sv
package blx_pkg;

   typedef enum logic [2:0] {
      EV_NONE  = 3'd0,
      EV_RST   = 3'd1,
      EV_REDIR = 3'd2,
      EV_EXC   = 3'd3,
      EV_BRK   = 3'd4,
      EV_NMI   = 3'd5,
      EV_IRQ   = 3'd6,
      EV_RTE   = 3'd7
   } ev_e;

   function automatic logic ev_saves(input ev_e ev);
      return (ev == EV_EXC) || (ev == EV_BRK) || (ev == EV_NMI) || (ev == EV_IRQ);
   endfunction

endpackage

// File: rtl/blx_arbiter.sv
module blx_arbiter
   import blx_pkg::*;
(
   input  logic bnd_i,
   input  logic bl_i,
   input  logic sleep_i,
   input  logic nmi_ovr_i,
   input  logic rst_req_i,
   input  logic exc_req_i,
   input  logic brk_req_i,
   input  logic nmi_req_i,
   input  logic irq_req_i,
   input  logic rte_i,
   output ev_e  ev_o
);

   logic brk_live;
   logic nmi_live;
   logic irq_live;

   // qualification of each source by the block bit
   assign brk_live = brk_req_i && !bl_i;
   assign nmi_live = nmi_req_i && (!bl_i || nmi_ovr_i || sleep_i);
   assign irq_live = irq_req_i && (!bl_i || sleep_i);

   always_comb begin
      ev_o = EV_NONE;
      if (bnd_i) begin
         if (rst_req_i)      ev_o = EV_RST;
         else if (exc_req_i) ev_o = bl_i ? EV_REDIR : EV_EXC;
         else if (brk_live)  ev_o = EV_BRK;
         else if (nmi_live)  ev_o = EV_NMI;
         else if (irq_live)  ev_o = EV_IRQ;
         else if (rte_i)     ev_o = EV_RTE;
      end
   end

endmodule

// File: rtl/blx_target.sv
module blx_target
   import blx_pkg::*;
#(
   parameter int unsigned         ADDR_W    = 32,
   parameter logic [ADDR_W-1:0]   RESET_VEC = 32'hA000_0000,
   parameter logic [ADDR_W-1:0]   EXC_OFS   = 32'h0000_0100,
   parameter logic [ADDR_W-1:0]   INT_OFS   = 32'h0000_0600,
   parameter bit                  VBR_ADD   = 1'b1
)(
   input  ev_e               ev_i,
   input  logic [ADDR_W-1:0] vbr_i,
   input  logic [ADDR_W-1:0] spc_i,
   output logic [ADDR_W-1:0] tgt_o
);

   localparam logic [ADDR_W-1:0] OFS_UNION = EXC_OFS | INT_OFS;

   if (ADDR_W < 8) begin : g_bad_width
      $error("blx_target: ADDR_W too small");
   end
   if (EXC_OFS == INT_OFS) begin : g_bad_ofs
      $error("blx_target: exception and interrupt offsets must differ");
   end

   logic [ADDR_W-1:0] exc_vec;
   logic [ADDR_W-1:0] int_vec;

   if (VBR_ADD) begin : g_add
      assign exc_vec = vbr_i + EXC_OFS;
      assign int_vec = vbr_i + INT_OFS;
   end else begin : g_or
      // base must keep offset bits clear in this variant
      assign exc_vec = (vbr_i & ~OFS_UNION) | EXC_OFS;
      assign int_vec = (vbr_i & ~OFS_UNION) | INT_OFS;
   end

   always_comb begin
      unique case (ev_i)
         EV_RST, EV_REDIR: tgt_o = RESET_VEC;
         EV_EXC, EV_BRK:   tgt_o = exc_vec;
         EV_NMI, EV_IRQ:   tgt_o = int_vec;
         EV_RTE:           tgt_o = spc_i;
         default:          tgt_o = '0;
      endcase
   end

endmodule

// File: rtl/blx_state.sv
module blx_state
   import blx_pkg::*;
#(
   parameter int unsigned         ADDR_W   = 32,
   parameter int unsigned         SR_W     = 32,
   parameter int unsigned         CODE_W   = 12,
   parameter int unsigned         BL_BIT   = 28,
   parameter logic [SR_W-1:0]     SR_INIT  = 32'h7000_00F0,
   parameter logic [CODE_W-1:0]   RST_CODE = 12'h000,
   parameter logic [CODE_W-1:0]   NMI_CODE = 12'h1C0,
   parameter logic [CODE_W-1:0]   BRK_CODE = 12'h1E0
)(
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  ev_e               ev_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [CODE_W-1:0] exc_code_i,
   input  logic [CODE_W-1:0] irq_code_i,
   input  logic              sr_we_i,
   input  logic [SR_W-1:0]   sr_wdata_i,
   input  logic              vbr_we_i,
   input  logic [ADDR_W-1:0] vbr_wdata_i,
   output logic [SR_W-1:0]   sr_o,
   output logic [SR_W-1:0]   ssr_o,
   output logic [ADDR_W-1:0] spc_o,
   output logic [ADDR_W-1:0] vbr_o,
   output logic [CODE_W-1:0] evt_o
);

   localparam logic [SR_W-1:0] BL_MASK = SR_W'(1) << BL_BIT;

   if (BL_BIT >= SR_W) begin : g_bad_bl
      $error("blx_state: BL_BIT outside SR");
   end
   if (SR_INIT[BL_BIT] != 1'b1) begin : g_bad_init
      $error("blx_state: SR_INIT must have the block bit set");
   end

   logic              saves;
   logic [CODE_W-1:0] new_code;

   assign saves = ev_saves(ev_i);

   always_comb begin
      unique case (ev_i)
         EV_EXC:  new_code = exc_code_i;
         EV_BRK:  new_code = BRK_CODE;
         EV_NMI:  new_code = NMI_CODE;
         EV_IRQ:  new_code = irq_code_i;
         default: new_code = RST_CODE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         sr_o  <= SR_INIT;
         vbr_o <= '0;
         evt_o <= RST_CODE;
      end else begin
         unique case (ev_i)
            EV_RST: begin
               sr_o  <= SR_INIT;
               vbr_o <= '0;
               evt_o <= RST_CODE;
            end
            EV_EXC, EV_BRK, EV_NMI, EV_IRQ: begin
               sr_o  <= sr_o | BL_MASK;
               evt_o <= new_code;
            end
            EV_RTE: sr_o <= ssr_o;
            EV_REDIR: ;
            default: begin
               if (sr_we_i)  sr_o  <= sr_wdata_i;
               if (vbr_we_i) vbr_o <= vbr_wdata_i;
            end
         endcase
      end
   end

   // saved copies carry no reset value
   always_ff @(posedge clk_i) begin
      if (saves) begin
         spc_o <= pc_i;
         ssr_o <= sr_o;
      end
   end

   AST_BL_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_n_i) saves |=> sr_o[BL_BIT]); // R10
   AST_SAVE_PC: assert property (@(posedge clk_i) disable iff (!rst_n_i) saves |=> spc_o == $past(pc_i)); // R10
   AST_RTE_SR: assert property (@(posedge clk_i) disable iff (!rst_n_i) (ev_i == EV_RTE) |=> sr_o == $past(ssr_o)); // R8
   AST_VBR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n_i) (ev_i == EV_RST) |=> vbr_o == '0); // R7
   AST_WRITE_DROP: assert property (@(posedge clk_i) disable iff (!rst_n_i) (ev_i != EV_NONE && ev_i != EV_RST) |=> $stable(vbr_o)); // R12

endmodule

// File: rtl/bl_accept_ctrl.sv
module bl_accept_ctrl
   import blx_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned SR_W    = 32,
   parameter int unsigned CODE_W  = 12,
   parameter int unsigned BL_BIT  = 28,
   parameter bit          VBR_ADD = 1'b1
)(
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              bnd_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              sleep_i,
   input  logic              nmi_ovr_i,
   input  logic              rst_req_i,
   input  logic              exc_req_i,
   input  logic [CODE_W-1:0] exc_code_i,
   input  logic              brk_req_i,
   input  logic              nmi_req_i,
   input  logic              irq_req_i,
   input  logic [CODE_W-1:0] irq_code_i,
   input  logic              rte_i,
   input  logic              sr_we_i,
   input  logic [SR_W-1:0]   sr_wdata_i,
   input  logic              vbr_we_i,
   input  logic [ADDR_W-1:0] vbr_wdata_i,
   output logic              jump_o,
   output logic [ADDR_W-1:0] jump_pc_o,
   output logic              stat_en_o,
   output logic [1:0]        stat_o,
   output logic [SR_W-1:0]   sr_o,
   output logic [ADDR_W-1:0] spc_o,
   output logic [SR_W-1:0]   ssr_o,
   output logic [ADDR_W-1:0] vbr_o,
   output logic [CODE_W-1:0] evt_o
);

   localparam logic [ADDR_W-1:0] RESET_VEC = ADDR_W'(32'hA000_0000);
   localparam logic [ADDR_W-1:0] EXC_OFS   = ADDR_W'(32'h0000_0100);
   localparam logic [ADDR_W-1:0] INT_OFS   = ADDR_W'(32'h0000_0600);
   localparam logic [SR_W-1:0]   SR_INIT   = SR_W'(32'h7000_00F0);
   localparam logic [1:0]        STAT_RST  = 2'b11;

   ev_e               ev;
   logic [ADDR_W-1:0] tgt;

   blx_arbiter u_arb (
      .bnd_i     (bnd_i),
      .bl_i      (sr_o[BL_BIT]),
      .sleep_i   (sleep_i),
      .nmi_ovr_i (nmi_ovr_i),
      .rst_req_i (rst_req_i),
      .exc_req_i (exc_req_i),
      .brk_req_i (brk_req_i),
      .nmi_req_i (nmi_req_i),
      .irq_req_i (irq_req_i),
      .rte_i     (rte_i),
      .ev_o      (ev)
   );

   blx_target #(
      .ADDR_W    (ADDR_W),
      .RESET_VEC (RESET_VEC),
      .EXC_OFS   (EXC_OFS),
      .INT_OFS   (INT_OFS),
      .VBR_ADD   (VBR_ADD)
   ) u_tgt (
      .ev_i  (ev),
      .vbr_i (vbr_o),
      .spc_i (spc_o),
      .tgt_o (tgt)
   );

   blx_state #(
      .ADDR_W  (ADDR_W),
      .SR_W    (SR_W),
      .CODE_W  (CODE_W),
      .BL_BIT  (BL_BIT),
      .SR_INIT (SR_INIT)
   ) u_state (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_i),
      .ev_i        (ev),
      .pc_i        (pc_i),
      .exc_code_i  (exc_code_i),
      .irq_code_i  (irq_code_i),
      .sr_we_i     (sr_we_i),
      .sr_wdata_i  (sr_wdata_i),
      .vbr_we_i    (vbr_we_i),
      .vbr_wdata_i (vbr_wdata_i),
      .sr_o        (sr_o),
      .ssr_o       (ssr_o),
      .spc_o       (spc_o),
      .vbr_o       (vbr_o),
      .evt_o       (evt_o)
   );

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         jump_o    <= 1'b0;
         jump_pc_o <= '0;
         stat_en_o <= 1'b0;
         stat_o    <= 2'b00;
      end else begin
         jump_o    <= (ev != EV_NONE);
         stat_en_o <= (ev == EV_RST);
         stat_o    <= (ev == EV_RST) ? STAT_RST : 2'b00;
         if (ev != EV_NONE) jump_pc_o <= tgt;
      end
   end

   AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i) (ev == EV_IRQ) |-> (!sr_o[BL_BIT] || sleep_i)); // R1
   AST_BRK_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_n_i) (bnd_i && sr_o[BL_BIT]) |-> (ev != EV_BRK)); // R5
   AST_REDIR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i) (ev == EV_REDIR) |=> (jump_o && !stat_en_o && jump_pc_o == RESET_VEC)); // R6
   AST_STAT_ON_RST: assert property (@(posedge clk_i) disable iff (!rst_n_i) stat_en_o |-> (jump_o && jump_pc_o == RESET_VEC && sr_o == SR_INIT)); // R7
   AST_NMI_GATE: assert property (@(posedge clk_i) disable iff (!rst_n_i) (ev == EV_NMI) |-> (!sr_o[BL_BIT] || nmi_ovr_i || sleep_i)); // R4
   AST_RST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_n_i) (bnd_i && rst_req_i) |-> (ev == EV_RST)); // R11

endmodule

// File: tb/bl_accept_ctrl_test.sv
`timescale 1ns/1ps
module bl_accept_ctrl_test;

   localparam logic [31:0] RVEC   = 32'hA000_0000;
   localparam logic [31:0] SRINIT = 32'h7000_00F0;
   localparam logic [31:0] BLM    = 32'h1000_0000;
   localparam logic [11:0] C_EXC  = 12'h0A0;
   localparam logic [11:0] C_IRQ  = 12'h320;
   localparam logic [11:0] C_NMI  = 12'h1C0;
   localparam logic [11:0] C_BRK  = 12'h1E0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bnd, sleep, ovr, rstq, excq, brkq, nmiq, irqq, rte, srwe, vbrwe;
   logic [31:0] pc, srwd, vbrwd;
   logic [11:0] exc_code, irq_code;
   logic        jump, stat_en;
   logic [1:0]  stat;
   logic [31:0] jpc, sr, spc, ssr, vbr;
   logic [11:0] evt;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   bl_accept_ctrl uut (
      .clk_i(clk), .rst_n_i(rst_n), .bnd_i(bnd), .pc_i(pc), .sleep_i(sleep),
      .nmi_ovr_i(ovr), .rst_req_i(rstq), .exc_req_i(excq), .exc_code_i(exc_code),
      .brk_req_i(brkq), .nmi_req_i(nmiq), .irq_req_i(irqq), .irq_code_i(irq_code),
      .rte_i(rte), .sr_we_i(srwe), .sr_wdata_i(srwd), .vbr_we_i(vbrwe),
      .vbr_wdata_i(vbrwd), .jump_o(jump), .jump_pc_o(jpc), .stat_en_o(stat_en),
      .stat_o(stat), .sr_o(sr), .spc_o(spc), .ssr_o(ssr), .vbr_o(vbr), .evt_o(evt)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      bnd = 0; sleep = 0; ovr = 0; rstq = 0; excq = 0; brkq = 0; nmiq = 0;
      irqq = 0; rte = 0; srwe = 0; vbrwe = 0; pc = '0; srwd = '0; vbrwd = '0;
      exc_code = C_EXC; irq_code = C_IRQ;
   endtask

   // 0 none 1 rst 2 redir 3 exc 4 brk 5 nmi 6 irq 7 rte
   function automatic int model(input logic [8:0] v);
      logic b, s, o;
      b = v[0]; s = v[1]; o = v[2];
      if (v[3]) return 1;
      if (v[4]) return b ? 2 : 3;
      if (v[5] && !b) return 4;
      if (v[6] && (!b || o || s)) return 5;
      if (v[7] && (!b || s)) return 6;
      if (v[8]) return 7;
      return 0;
   endfunction

   function automatic string tag_of(input int k, input logic [8:0] v);
      case (k)
         1: return "R7";
         2: return "R6";
         3: return "R10";
         4: return "R5";
         5: return "R4";
         6: return v[0] ? "R3" : "R10";
         7: return "R8";
         default: begin
            if (v[5] && v[0]) return "R5";
            if (v[7] && v[0]) return "R1";
            if (v[6] && v[0]) return "R4";
            return "R11";
         end
      endcase
   endfunction

   task automatic sweep_one(input int idx);
      logic [8:0]  v;
      logic [31:0] prime_pc, tsr, tvbr, tpc, e_pc;
      int          k;
      string       t;
      v        = idx[8:0];
      prime_pc = 32'h1000_0000 + 32'(idx) * 4;
      tsr      = (32'(v[0]) << 28) | (32'(idx) << 12) | 32'h0F0;
      tvbr     = 32'h8000_0000 | (32'(idx) << 12);
      tpc      = 32'h2000_0000 + 32'(idx) * 8;
      // prime the saved registers with a known exception
      @(negedge clk); idle(); srwe = 1; srwd = 32'h0F0;
      @(negedge clk); idle(); bnd = 1; excq = 1; pc = prime_pc;
      @(negedge clk); idle(); srwe = 1; srwd = tsr; vbrwe = 1; vbrwd = tvbr;
      @(negedge clk); idle(); bnd = 1; pc = tpc;
      {rte, irqq, nmiq, brkq, excq, rstq, ovr, sleep} = v[8:1];
      @(negedge clk);
      k = model(v);
      t = tag_of(k, v);
      chk(t, 32'(jump), 32'(k != 0));
      case (k)
         1, 2:    e_pc = RVEC;
         3, 4:    e_pc = tvbr + 32'h100;
         5, 6:    e_pc = tvbr + 32'h600;
         default: e_pc = prime_pc;
      endcase
      if (k != 0) chk(t, jpc, e_pc);
      chk(t, 32'(stat_en), 32'(k == 1));
      if (k == 1) chk("R7", 32'(stat), 32'h3);
      case (k)
         1:          chk("R7", sr, SRINIT);
         3, 4, 5, 6: chk("R10", sr, tsr | BLM);
         7:          chk("R8", sr, 32'h0F0);
         0:          chk(t, sr, tsr);
         default: ;
      endcase
      chk(k == 1 ? "R7" : "R11", vbr, (k == 1) ? 32'h0 : tvbr);
      if (k >= 3 && k <= 6) begin
         chk("R10", spc, tpc);
         chk("R10", ssr, tsr);
         case (k)
            3: chk("R10", 32'(evt), 32'(C_EXC));
            4: chk("R5",  32'(evt), 32'(C_BRK));
            5: chk("R4",  32'(evt), 32'(C_NMI));
            default: chk("R10", 32'(evt), 32'(C_IRQ));
         endcase
      end
      idle();
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9", vbr, 32'h0);
      chk("R9", sr, SRINIT);
      chk("R9", 32'(evt), 32'h0);
      chk("R9", 32'(jump), 32'h0);
      chk("R9", 32'(stat_en), 32'h0);

      // R2: clearing write coincides with a pending interrupt
      @(negedge clk); idle(); srwe = 1; srwd = BLM | 32'h0F0; vbrwe = 1; vbrwd = 32'h8800_0000;
      @(negedge clk); idle(); srwe = 1; srwd = 32'h0F0; bnd = 1; irqq = 1;
      @(negedge clk);
      chk("R2", 32'(jump), 32'h0);
      chk("R2", sr, 32'h0F0);
      idle(); bnd = 1; irqq = 1; pc = 32'h0000_4444;
      @(negedge clk);
      chk("R2", 32'(jump), 32'h1);
      chk("R2", jpc, 32'h8800_0600);
      chk("R10", spc, 32'h0000_4444);

      // R12: writes at a taken boundary are dropped
      @(negedge clk); idle(); srwe = 1; srwd = 32'h0F0;
      @(negedge clk); idle(); bnd = 1; nmiq = 1; srwe = 1; srwd = 32'h0000_0ABC;
      vbrwe = 1; vbrwd = 32'h9000_0000;
      @(negedge clk);
      chk("R12", sr, BLM | 32'h0F0);
      chk("R12", vbr, 32'h8800_0000);
      chk("R4", jpc, 32'h8800_0600);
      idle(); bnd = 1; rstq = 1; vbrwe = 1; vbrwd = 32'h9000_0000;
      @(negedge clk);
      chk("R12", vbr, 32'h0);
      idle();

      for (int i = 0; i < 512; i++) sweep_one(i);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule